// File: doc/BRIEF.md
# Half-Page Read Step Sequencer

This block turns a byte-range read request against a flash array into an ordered list of device read steps. The array is organised in 256-byte correction units; a page holds either one unit (small mode) or two units (large mode). From a start offset and a byte length, the block derives the first page, the half of the page holding the first byte and the column inside that half. It then issues one step per unit touched, each carrying the read opcode, the page, the starting column, the byte count to deliver and the spare-area offset of that unit's check bytes.

A request is taken with a one-cycle `start_i` strobe while the block is idle. Steps leave through a valid/ready handshake; the downstream pin sequencer accepts each step once it has moved the bytes. A request reaching past the end of the device is refused at once with a one-cycle error pulse. A one-cycle done pulse follows the acceptance of the final step.

Top module: `page_walk_rd`

## Requirements
- R1: The first step's page is offset>>8 in small mode (`big_page_i`=0) and offset>>9 in large mode; its column is offset bits [7:0]; in large mode offset bit 8 selects the starting half, in small mode the half is always 0.
- R2: A half-0 step carries opcode 8'h00 and a half-1 step carries opcode 8'h01; in small mode every step carries 8'h00.
- R3: Each step's byte count is the smaller of (256 - column) and the bytes still owed, and is never zero.
- R4: Every step after the first in a request has column 0.
- R5: In small mode the page rises by one after every step; in large mode the half toggles after every step and the page rises by one only after a half-1 step.
- R6: A request with offset + length greater than DEV_SIZE emits no step and no done pulse; `err_o` is high for exactly the one cycle after the start strobe.
- R7: `done_o` is high for one cycle, the cycle after the last step is accepted, when the counts sum to the length; a zero-length request in range gives `done_o` the cycle after the strobe with no step.
- R8: While `step_valid_o` is high and `step_ready_i` low, all step fields hold their values.
- R9: `step_ecc_ofs_o` is 0 on half-0 steps and 3 on half-1 steps.
- R10: A start strobe while a request is in progress is ignored and does not alter the steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken only when idle |
| ofs_i | input | OFS_W | Byte offset of the first byte |
| len_i | input | LEN_W | Number of bytes to read |
| big_page_i | input | 1 | 1 selects 512-byte pages, 0 selects 256-byte pages |
| busy_o | output | 1 | A request is being walked |
| step_valid_o | output | 1 | A step is offered |
| step_ready_i | input | 1 | Downstream accepts the offered step |
| step_op_o | output | 8 | Read opcode for the step's half |
| step_page_o | output | OFS_W-8 | Page number of the step |
| step_col_o | output | 8 | Starting column inside the 256-byte unit |
| step_cnt_o | output | 9 | Bytes to deliver, 1 to 256 |
| step_ecc_ofs_o | output | 3 | Spare-area offset of the unit's check bytes |
| err_o | output | 1 | One-cycle pulse on a refused request |
| done_o | output | 1 | One-cycle pulse when the request is complete |

## Verification
The assertions assume the downstream side never changes the block's view of a step except by raising `step_ready_i`, and that `big_page_i`, `ofs_i` and `len_i` matter only in the cycle of an accepted strobe; the mode is latched then, so the large-mode pairing checks hold even if the input later moves. The stimulus drives every input on the falling edge, keeps `step_ready_i` low on alternate steps to exercise holding, and raises a stray strobe only while a request is stalled, so the hold and ignore properties see both stalled and flowing traffic.

// File: rtl/page_walk_pkg.sv
package page_walk_pkg;
  localparam int unsigned UNIT_BYTES = 256;
  localparam logic [7:0] OP_HALF0 = 8'h00;
  localparam logic [7:0] OP_HALF1 = 8'h01;
  localparam logic [2:0] ECC_OFS_H0 = 3'd0;
  localparam logic [2:0] ECC_OFS_H1 = 3'd3;

  typedef enum logic {ST_IDLE, ST_STEP} walk_state_e;
endpackage

// File: rtl/pw_range_chk.sv
module pw_range_chk #(
  parameter int OFS_W    = 17,
  parameter int LEN_W    = 17,
  parameter int DEV_SIZE = 65536
) (
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             over_o
);
  localparam int SUM_W = ((OFS_W > LEN_W) ? OFS_W : LEN_W) + 1;
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'(DEV_SIZE);

  logic [SUM_W-1:0] end_q;
  assign end_q  = SUM_W'(ofs_i) + SUM_W'(len_i);
  assign over_o = end_q > LIMIT;
endmodule

// File: rtl/pw_addr_split.sv
module pw_addr_split #(
  parameter int OFS_W = 17,
  localparam int PAGE_W = OFS_W - 8
) (
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic              big_i,
  output logic [PAGE_W-1:0] page_o,
  output logic              half_o,
  output logic [7:0]        col_o
);
  always_comb begin
    if (big_i) begin
      page_o = {1'b0, ofs_i[OFS_W-1:9]};
      half_o = ofs_i[8];
    end else begin
      page_o = ofs_i[OFS_W-1:8];
      half_o = 1'b0;
    end
    col_o = ofs_i[7:0];
  end
endmodule

// File: rtl/pw_step_size.sv
module pw_step_size #(
  parameter int LEN_W = 17
) (
  input  logic [7:0]       col_i,
  input  logic [LEN_W-1:0] rem_i,
  output logic [8:0]       cnt_o,
  output logic             last_o
);
  logic [8:0]       avail;
  logic [LEN_W-1:0] avail_w;

  assign avail   = 9'd256 - {1'b0, col_i};
  assign avail_w = LEN_W'(avail);

  always_comb begin
    if (rem_i < avail_w) cnt_o = rem_i[8:0];
    else                 cnt_o = avail;
    last_o = rem_i <= avail_w;
  end
endmodule

// File: rtl/page_walk_rd.sv
module page_walk_rd
  import page_walk_pkg::*;
#(
  parameter int OFS_W    = 17,
  parameter int LEN_W    = 17,
  parameter int DEV_SIZE = 65536,
  localparam int PAGE_W  = OFS_W - 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              big_page_i,
  output logic              busy_o,
  output logic              step_valid_o,
  input  logic              step_ready_i,
  output logic [7:0]        step_op_o,
  output logic [PAGE_W-1:0] step_page_o,
  output logic [7:0]        step_col_o,
  output logic [8:0]        step_cnt_o,
  output logic [2:0]        step_ecc_ofs_o,
  output logic              err_o,
  output logic              done_o
);
  walk_state_e       state_q;
  logic [PAGE_W-1:0] page_q;
  logic              half_q;
  logic [7:0]        col_q;
  logic [LEN_W-1:0]  rem_q;
  logic              big_q;
  logic              err_q, done_q;

  logic              over;
  logic [PAGE_W-1:0] page_init;
  logic              half_init;
  logic [7:0]        col_init;
  logic [8:0]        cnt;
  logic              last;
  logic              take, fire;

  pw_range_chk #(.OFS_W(OFS_W), .LEN_W(LEN_W), .DEV_SIZE(DEV_SIZE)) u_range (
    .ofs_i (ofs_i),
    .len_i (len_i),
    .over_o(over)
  );

  pw_addr_split #(.OFS_W(OFS_W)) u_split (
    .ofs_i (ofs_i),
    .big_i (big_page_i),
    .page_o(page_init),
    .half_o(half_init),
    .col_o (col_init)
  );

  pw_step_size #(.LEN_W(LEN_W)) u_size (
    .col_i (col_q),
    .rem_i (rem_q),
    .cnt_o (cnt),
    .last_o(last)
  );

  assign take = (state_q == ST_IDLE) && start_i;
  assign fire = (state_q == ST_STEP) && step_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      half_q  <= 1'b0;
      col_q   <= '0;
      rem_q   <= '0;
      big_q   <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      err_q  <= 1'b0;
      done_q <= 1'b0;
      if (take) begin
        if (over) begin
          err_q <= 1'b1;
        end else if (len_i == '0) begin
          done_q <= 1'b1;
        end else begin
          page_q  <= page_init;
          half_q  <= half_init;
          col_q   <= col_init;
          rem_q   <= len_i;
          big_q   <= big_page_i;
          state_q <= ST_STEP;
        end
      end else if (fire) begin
        rem_q <= rem_q - LEN_W'(cnt);
        col_q <= '0;
        if (!big_q || half_q) page_q <= page_q + 1'b1;
        if (big_q) half_q <= ~half_q;
        if (last) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  assign busy_o         = state_q == ST_STEP;
  assign step_valid_o   = state_q == ST_STEP;
  assign step_op_o      = half_q ? OP_HALF1 : OP_HALF0;
  assign step_page_o    = page_q;
  assign step_col_o     = col_q;
  assign step_cnt_o     = cnt;
  assign step_ecc_ofs_o = half_q ? ECC_OFS_H1 : ECC_OFS_H0;
  assign err_o          = err_q;
  assign done_o         = done_q;

  // handshake hold
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_valid_o && !step_ready_i |=> step_valid_o && $stable(step_op_o) &&
    $stable(step_page_o) && $stable(step_col_o) && $stable(step_cnt_o));

  assert_cnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_valid_o |-> (step_cnt_o != 9'd0) && (({1'b0, step_col_o} + {1'b0, step_cnt_o}) <= 10'd256));

  assert_col_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_valid_o && step_ready_i |=> !step_valid_o || (step_col_o == 8'd0));

  assert_small_op_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_valid_o && !big_q |-> (step_op_o == OP_HALF0) && (step_ecc_ofs_o == ECC_OFS_H0));

  assert_half_pair_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_valid_o && step_ready_i && big_q && (step_op_o == OP_HALF0) |=>
    !step_valid_o || ((step_op_o == OP_HALF1) && (step_page_o == $past(step_page_o))));

  assert_err_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !step_valid_o && !done_o);

  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !step_valid_o);
endmodule

// File: tb/tb_page_walk_rd.sv
`timescale 1ns/1ps
module tb_page_walk_rd;
  localparam int OFS_W = 17;
  localparam int LEN_W = 17;
  localparam int PAGE_W = OFS_W - 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [OFS_W-1:0]  ofs = '0;
  logic [LEN_W-1:0]  len = '0;
  logic              big = 1'b0;
  logic              busy, vld, rdy = 1'b0;
  logic [7:0]        op;
  logic [PAGE_W-1:0] page;
  logic [7:0]        col;
  logic [8:0]        cnt;
  logic [2:0]        ecc;
  logic              err, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  page_walk_rd dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ofs_i(ofs), .len_i(len),
    .big_page_i(big), .busy_o(busy), .step_valid_o(vld), .step_ready_i(rdy),
    .step_op_o(op), .step_page_o(page), .step_col_o(col), .step_cnt_o(cnt),
    .step_ecc_ofs_o(ecc), .err_o(err), .done_o(done)
  );

  typedef struct packed {
    logic [16:0] v_ofs;
    logic [16:0] v_len;
    logic        v_big;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{17'h00000, 17'd256,  1'b0},
    '{17'h00110, 17'd600,  1'b0},
    '{17'h00010, 17'd1000, 1'b1},
    '{17'h00345, 17'd50,   1'b1},
    '{17'h003F0, 17'd40,   1'b1},
    '{17'h001FF, 17'd1,    1'b1},
    '{17'h00100, 17'd512,  1'b1},
    '{17'h0FF00, 17'd256,  1'b0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic fields(input string req, input int e_op, input int e_pg,
                        input int e_col, input int e_cnt, input int e_ecc);
    chk(req, "valid", int'(vld), 1);
    chk(req, "opcode", int'(op), e_op);
    chk(req, "page", int'(page), e_pg);
    chk(req, "column", int'(col), e_col);
    chk(req, "count", int'(cnt), e_cnt);
    chk(req, "ecc offset", int'(ecc), e_ecc);
  endtask

  // bench model: R1 split, R2/R9 codes, R3 sizing, R4 column, R5 advance
  task automatic run_req(input int a_ofs, input int a_len, input bit a_big, input bit poke);
    int pg, hf, cl, rem, n, c;
    @(negedge clk);
    ofs = OFS_W'(a_ofs); len = LEN_W'(a_len); big = a_big; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    pg = a_big ? (a_ofs >> 9) : (a_ofs >> 8);
    hf = a_big ? ((a_ofs >> 8) & 1) : 0;
    cl = a_ofs & 255;
    rem = a_len;
    n = 0;
    while (rem > 0) begin
      c = (256 - cl < rem) ? 256 - cl : rem;
      fields(n == 0 ? "R1" : "R5", hf ? 1 : 0, pg, cl, c, hf ? 3 : 0);
      if (n > 0) chk("R4", "column after first", int'(col), 0);
      chk("R3", "count", int'(cnt), c);
      chk("R2", "opcode", int'(op), hf ? 1 : 0);
      chk("R9", "ecc offset", int'(ecc), hf ? 3 : 0);
      if ((n % 2) == 1 || poke) begin
        if (poke) begin
          ofs = 17'h00500; len = 17'd10; big = ~a_big; start = 1'b1;
        end
        @(negedge clk);
        start = 1'b0;
        fields(poke ? "R10" : "R8", hf ? 1 : 0, pg, cl, c, hf ? 3 : 0);
        poke = 1'b0;
      end
      rdy = 1'b1;
      @(negedge clk);
      rdy = 1'b0;
      rem -= c;
      cl = 0;
      if (!a_big || hf == 1) pg++;
      if (a_big) hf ^= 1;
      n++;
      if (rem > 0) chk("R7", "done early", int'(done), 0);
    end
    chk("R7", "done pulse", int'(done), 1);
    chk("R7", "valid after last", int'(vld), 0);
    @(negedge clk);
    chk("R7", "done width", int'(done), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7", "reset valid", int'(vld), 0);
    chk("R7", "reset done", int'(done), 0);
    chk("R6", "reset err", int'(err), 0);
    chk("R10", "reset busy", int'(busy), 0);

    for (int i = 0; i < 8; i++)
      run_req(int'(VECS[i].v_ofs), int'(VECS[i].v_len), VECS[i].v_big, 1'b0);

    // stray start while stalled
    run_req(0, 300, 1'b0, 1'b1);

    // out of range
    @(negedge clk);
    ofs = 17'd65500; len = 17'd100; big = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R6", "err pulse", int'(err), 1);
    chk("R6", "no step", int'(vld), 0);
    chk("R6", "no done", int'(done), 0);
    @(negedge clk);
    chk("R6", "err width", int'(err), 0);
    chk("R6", "still no step", int'(vld), 0);

    // just past end in large mode
    ofs = 17'h0FE00; len = 17'd513; big = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R6", "err one over", int'(err), 1);
    chk("R6", "no step one over", int'(vld), 0);

    // zero length
    @(negedge clk);
    ofs = 17'd5; len = 17'd0; big = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7", "zero length done", int'(done), 1);
    chk("R7", "zero length no step", int'(vld), 0);
    chk("R6", "zero length no err", int'(err), 0);
    @(negedge clk);
    chk("R7", "zero length done width", int'(done), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule